// File: doc/BRIEF.md
# Block-Cipher Register Front-End

This block is the register bank and launch sequencer that sits between a 32-bit register bus and a 128-bit block-cipher engine. Software writes a control word, up to eight key words, four chaining-vector words and four input words, and reads back four result words. The block keeps these values in registers and presents them to the engine on wide parallel buses. It also presents the decoded key-size code, chaining mode, direction and key-preparation request. The cipher arithmetic itself lives in the engine, which is outside this block.

A run starts without a separate command. When start mode and autostart are both enabled, writing the input word at offset 0x40 launches exactly one block operation. The busy bit stays set until the engine reports completion and the result words have been captured. Software loads a key with its first word in the highest key register in use, and its last word always lands in K0. The key therefore sits right-aligned on the engine's key bus.

Top module: `cipher_reg_frontend`

## Requirements
- R1: After synchronous reset every register reads as zero, busy is clear, and no start pulse is issued.
- R2: Register map by byte offset: control 0x00, K7..K0 at 0x04..0x20, IV3..IV0 at 0x24..0x30, ID3..ID0 at 0x34..0x40, OD3..OD0 at 0x44..0x50. Writes take effect in one cycle. Read data appears the cycle after the read strobe. Key words read as zero, and so do unmapped offsets.
- R3: The key bus is {K7,...,K0}, with K0 in bits 31:0. Control bits 5:4 hold the key-size code: 0 is 128-bit, 1 is 192-bit, 2 is 256-bit. A key written first-word-first into K3, K5 or K7 places its first word at the top of the used part of the bus.
- R4: Control bit 0 selects the direction (0 encrypt, 1 decrypt). Control bits 3:1 select the chaining mode (0 ECB, 1 CBC, 2 OFB, 3 CFB, 4 CTR). Both are driven unchanged to the engine.
- R5: Control bit 6 enables start mode and bit 7 enables autostart. With both set, a write to offset 0x40 produces a one-cycle start pulse in the following cycle. With either bit clear, that write only stores data.
- R6: Control bit 10 (busy) rises with the launching write and falls when completion is signalled. At that same edge OD3..OD0 take result bits 127:96 down to 31:0.
- R7: While busy, writes to control, key, IV and input registers are dropped, and a write to 0x40 does not launch.
- R8: When control bit 9 (IV auto-update) is set, completion loads IV3..IV0 from the engine's next-IV bus. When it is clear, an operation leaves the IV registers unchanged.
- R9: Control bit 11 (key valid) is set by completion of an operation launched with control bit 8 (prepare key) set. It is cleared by any accepted key write. The key-preparation request to the engine is bit 8 OR (decrypt AND NOT key valid).
- R10: A launching write while the mode is 5..7 or the key code is 3 sets the sticky error bit, control bit 12, and starts nothing. Writing control with bit 12 set clears the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| eng_start | output | 1 | One-cycle launch pulse |
| eng_key | output | 256 | Key words K7..K0 |
| eng_key_code | output | 2 | Key-size code |
| eng_mode | output | 3 | Chaining mode |
| eng_decrypt | output | 1 | 1 = decrypt |
| eng_prep_key | output | 1 | Key pre-processing request |
| eng_iv | output | 128 | IV3..IV0 |
| eng_data | output | 128 | ID3..ID0 |
| eng_done | input | 1 | Engine completion pulse |
| eng_result | input | 128 | Engine result block |
| eng_next_iv | input | 128 | Engine chaining value for auto-update |

## Verification
A wrong sequencer state shows up at the start pin within the cycle that follows. A missed or extra start, or a busy bit that lingers after completion, appears there or in the next control read. A corrupted key, IV or input register reaches the engine buses in the same cycle. The bench compares those buses against its own model on every clock, so a dropped-write violation surfaces the cycle after the offending write. A broken capture shows on the output and IV readback right after the completion pulse. So does a wrongly gated auto-update.

// File: rtl/cfe_pkg.sv
package cfe_pkg;

    localparam int CFE_WORD_W    = 32;
    localparam int CFE_KEY_WORDS = 8;
    localparam int CFE_BLK_WORDS = 4;
    localparam int CFE_ADDR_W    = 8;
    localparam int CFE_IDX_W     = 3;

    localparam int CTRL_CFG_W    = 10;
    localparam int CTRL_BUSY_BIT = 10;
    localparam int CTRL_KV_BIT   = 11;
    localparam int CTRL_ERR_BIT  = 12;

    typedef enum logic [2:0] {
        MODE_ECB = 3'd0,
        MODE_CBC = 3'd1,
        MODE_OFB = 3'd2,
        MODE_CFB = 3'd3,
        MODE_CTR = 3'd4
    } chain_mode_e;

    typedef enum logic [1:0] {
        KSZ_128  = 2'd0,
        KSZ_192  = 2'd1,
        KSZ_256  = 2'd2,
        KSZ_RSVD = 2'd3
    } key_size_e;

    // configuration part of the control word, bit 0 at the bottom
    typedef struct packed {
        logic       iv_auto;
        logic       prep_key;
        logic       auto_sel;
        logic       start_mode;
        logic [1:0] key_code;
        logic [2:0] mode;
        logic       decrypt;
    } ctrl_cfg_t;

    typedef enum logic [2:0] {
        GRP_CTRL,
        GRP_KEY,
        GRP_IV,
        GRP_DIN,
        GRP_DOUT,
        GRP_NONE
    } reg_grp_e;

    typedef struct packed {
        reg_grp_e             grp;
        logic [CFE_IDX_W-1:0] idx;
    } reg_sel_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LAUNCH,
        SQ_WAIT
    } seq_state_e;

    // word offsets: control, then key words high to low, then IV, input, output
    function automatic reg_sel_t decode_word(input int word, input int key_words,
                                             input int blk_words);
        reg_sel_t s;
        int kb;
        int ib;
        int db;
        int ob;
        kb = 1;
        ib = kb + key_words;
        db = ib + blk_words;
        ob = db + blk_words;
        s.grp = GRP_NONE;
        s.idx = '0;
        if (word == 0) begin
            s.grp = GRP_CTRL;
        end else if (word < ib) begin
            s.grp = GRP_KEY;
            s.idx = CFE_IDX_W'(ib - 1 - word);
        end else if (word < db) begin
            s.grp = GRP_IV;
            s.idx = CFE_IDX_W'(db - 1 - word);
        end else if (word < ob) begin
            s.grp = GRP_DIN;
            s.idx = CFE_IDX_W'(ob - 1 - word);
        end else if (word < ob + blk_words) begin
            s.grp = GRP_DOUT;
            s.idx = CFE_IDX_W'(ob + blk_words - 1 - word);
        end
        return s;
    endfunction

    function automatic logic cfg_legal(input ctrl_cfg_t c);
        return (c.mode <= 3'(MODE_CTR)) && (c.key_code != 2'(KSZ_RSVD));
    endfunction

endpackage

// File: rtl/cfe_regfile.sv
module cfe_regfile
    import cfe_pkg::*;
#(
    parameter int WORD_W    = CFE_WORD_W,
    parameter int KEY_WORDS = CFE_KEY_WORDS,
    parameter int BLK_WORDS = CFE_BLK_WORDS,
    localparam int KEY_W    = WORD_W * KEY_WORDS,
    localparam int BLK_W    = WORD_W * BLK_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  reg_sel_t          sel,
    input  logic [WORD_W-1:0] wdata,
    input  logic              busy,
    input  logic              done,
    input  logic              iv_auto,
    input  logic [BLK_W-1:0]  next_iv,
    input  logic [BLK_W-1:0]  result,
    output logic [KEY_W-1:0]  key_flat,
    output logic [BLK_W-1:0]  iv_flat,
    output logic [BLK_W-1:0]  din_flat,
    output logic [BLK_W-1:0]  dout_flat
);

    logic [WORD_W-1:0] key_q  [KEY_WORDS];
    logic [WORD_W-1:0] iv_q   [BLK_WORDS];
    logic [WORD_W-1:0] din_q  [BLK_WORDS];
    logic [WORD_W-1:0] dout_q [BLK_WORDS];

    for (genvar g = 0; g < KEY_WORDS; g++) begin : g_key
        always_ff @(posedge clk) begin
            if (rst)
                key_q[g] <= '0;
            else if (we && sel.grp == GRP_KEY && sel.idx == CFE_IDX_W'(g))
                key_q[g] <= wdata;
        end
        assign key_flat[g*WORD_W +: WORD_W] = key_q[g];
    end

    for (genvar g = 0; g < BLK_WORDS; g++) begin : g_blk
        always_ff @(posedge clk) begin
            if (rst)
                iv_q[g] <= '0;
            else if (we && sel.grp == GRP_IV && sel.idx == CFE_IDX_W'(g))
                iv_q[g] <= wdata;
            else if (done && iv_auto)
                iv_q[g] <= next_iv[g*WORD_W +: WORD_W];
        end

        always_ff @(posedge clk) begin
            if (rst)
                din_q[g] <= '0;
            else if (we && sel.grp == GRP_DIN && sel.idx == CFE_IDX_W'(g))
                din_q[g] <= wdata;
        end

        always_ff @(posedge clk) begin
            if (rst)
                dout_q[g] <= '0;
            else if (done)
                dout_q[g] <= result[g*WORD_W +: WORD_W];
        end

        assign iv_flat[g*WORD_W +: WORD_W]   = iv_q[g];
        assign din_flat[g*WORD_W +: WORD_W]  = din_q[g];
        assign dout_flat[g*WORD_W +: WORD_W] = dout_q[g];
    end

    AST_KEY_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(key_flat)); // R7

    AST_IV_KEPT_NO_AUTO: assert property (@(posedge clk) disable iff (rst)
        (busy && !iv_auto) |=> $stable(iv_flat)); // R8

    AST_OUT_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(dout_flat)); // R6

endmodule

// File: rtl/cfe_sequencer.sv
module cfe_sequencer
    import cfe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic cfg_ok,
    input  logic prep_key,
    input  logic key_wr,
    input  logic err_clr,
    input  logic done,
    output logic busy,
    output logic start,
    output logic key_valid,
    output logic err
);

    seq_state_e state_q;
    logic       prep_lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SQ_IDLE;
            prep_lat_q <= 1'b0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (trig && cfg_ok) begin
                        state_q    <= SQ_LAUNCH;
                        prep_lat_q <= prep_key;
                    end
                end
                SQ_LAUNCH: state_q <= done ? SQ_IDLE : SQ_WAIT;
                SQ_WAIT:   if (done) state_q <= SQ_IDLE;
                default:   state_q <= SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            err <= 1'b0;
        else if (trig && !cfg_ok)
            err <= 1'b1;
        else if (err_clr)
            err <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            key_valid <= 1'b0;
        else if (busy && done && prep_lat_q)
            key_valid <= 1'b1;
        else if (key_wr)
            key_valid <= 1'b0;
    end

    assign busy  = (state_q != SQ_IDLE);
    assign start = (state_q == SQ_LAUNCH);

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !$past(busy)); // R5

    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy); // R6

    AST_ERR_NO_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> !busy); // R10

    AST_KV_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(key_valid) |-> $past(done)); // R9

endmodule

// File: rtl/cipher_reg_frontend.sv
module cipher_reg_frontend
    import cfe_pkg::*;
#(
    parameter int WORD_W    = CFE_WORD_W,
    parameter int KEY_WORDS = CFE_KEY_WORDS,
    parameter int BLK_WORDS = CFE_BLK_WORDS,
    parameter int ADDR_W    = CFE_ADDR_W,
    localparam int KEY_W    = WORD_W * KEY_WORDS,
    localparam int BLK_W    = WORD_W * BLK_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              eng_start,
    output logic [KEY_W-1:0]  eng_key,
    output logic [1:0]        eng_key_code,
    output logic [2:0]        eng_mode,
    output logic              eng_decrypt,
    output logic              eng_prep_key,
    output logic [BLK_W-1:0]  eng_iv,
    output logic [BLK_W-1:0]  eng_data,
    input  logic              eng_done,
    input  logic [BLK_W-1:0]  eng_result,
    input  logic [BLK_W-1:0]  eng_next_iv
);

    reg_sel_t          sel;
    ctrl_cfg_t         cfg_q;
    logic              busy, key_valid, err;
    logic              wr_ok, trig, key_wr, err_clr;
    logic [BLK_W-1:0]  dout_flat;
    logic [WORD_W-1:0] ctrl_word, rd_word;
    logic              unused_bits;

    assign sel     = decode_word(int'(bus_addr[ADDR_W-1:2]), KEY_WORDS, BLK_WORDS);
    assign wr_ok   = bus_wr && !busy;
    assign key_wr  = wr_ok && sel.grp == GRP_KEY;
    assign err_clr = wr_ok && sel.grp == GRP_CTRL && bus_wdata[CTRL_ERR_BIT];
    assign trig    = wr_ok && sel.grp == GRP_DIN && sel.idx == '0
                     && cfg_q.start_mode && cfg_q.auto_sel;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (wr_ok && sel.grp == GRP_CTRL)
            cfg_q <= ctrl_cfg_t'(bus_wdata[CTRL_CFG_W-1:0]);
    end

    cfe_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .cfg_ok    (cfg_legal(cfg_q)),
        .prep_key  (cfg_q.prep_key),
        .key_wr    (key_wr),
        .err_clr   (err_clr),
        .done      (eng_done),
        .busy      (busy),
        .start     (eng_start),
        .key_valid (key_valid),
        .err       (err)
    );

    cfe_regfile #(
        .WORD_W    (WORD_W),
        .KEY_WORDS (KEY_WORDS),
        .BLK_WORDS (BLK_WORDS)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (wr_ok),
        .sel       (sel),
        .wdata     (bus_wdata),
        .busy      (busy),
        .done      (eng_done && busy),
        .iv_auto   (cfg_q.iv_auto),
        .next_iv   (eng_next_iv),
        .result    (eng_result),
        .key_flat  (eng_key),
        .iv_flat   (eng_iv),
        .din_flat  (eng_data),
        .dout_flat (dout_flat)
    );

    assign eng_key_code = cfg_q.key_code;
    assign eng_mode     = cfg_q.mode;
    assign eng_decrypt  = cfg_q.decrypt;
    assign eng_prep_key = cfg_q.prep_key || (cfg_q.decrypt && !key_valid);

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTRL_CFG_W-1:0] = cfg_q;
        ctrl_word[CTRL_BUSY_BIT]  = busy;
        ctrl_word[CTRL_KV_BIT]    = key_valid;
        ctrl_word[CTRL_ERR_BIT]   = err;
    end

    always_comb begin
        unique case (sel.grp)
            GRP_CTRL: rd_word = ctrl_word;
            GRP_IV:   rd_word = eng_iv[int'(sel.idx)*WORD_W +: WORD_W];
            GRP_DIN:  rd_word = eng_data[int'(sel.idx)*WORD_W +: WORD_W];
            GRP_DOUT: rd_word = dout_flat[int'(sel.idx)*WORD_W +: WORD_W];
            default:  rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else
            bus_rdata <= bus_rd ? rd_word : '0;
    end

    assign unused_bits = ^{bus_addr[1:0], bus_wdata};

    AST_NO_LAUNCH_BAD_CFG: assert property (@(posedge clk) disable iff (rst)
        (trig && !cfg_legal(cfg_q)) |=> !eng_start); // R10

    AST_BUSY_DROPS_WRITES: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_wr) |=> $stable(cfg_q)); // R7

endmodule

// File: tb/tb_cipher_reg_frontend.sv
`timescale 1ns/1ps
module tb_cipher_reg_frontend;

    localparam int LAT = 12;

    logic         clk = 1'b0;
    logic         rst;
    logic         bus_wr, bus_rd;
    logic [7:0]   bus_addr;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata;
    logic         eng_start, eng_decrypt, eng_prep_key, eng_done;
    logic [255:0] eng_key;
    logic [1:0]   eng_key_code;
    logic [2:0]   eng_mode;
    logic [127:0] eng_iv, eng_data, eng_result, eng_next_iv;

    always #4 clk = ~clk;

    cipher_reg_frontend dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_start(eng_start), .eng_key(eng_key), .eng_key_code(eng_key_code),
        .eng_mode(eng_mode), .eng_decrypt(eng_decrypt), .eng_prep_key(eng_prep_key),
        .eng_iv(eng_iv), .eng_data(eng_data), .eng_done(eng_done),
        .eng_result(eng_result), .eng_next_iv(eng_next_iv)
    );

    // ---------------- engine stand-in ----------------
    logic [127:0] s_res;
    int           s_cnt;
    always @(posedge clk) begin
        if (rst) begin
            s_cnt <= 0; eng_done <= 1'b0; s_res <= '0;
        end else begin
            eng_done <= 1'b0;
            if (eng_start) begin
                s_cnt <= LAT;
                s_res <= eng_decrypt ?
                    ~(eng_data ^ eng_iv ^ eng_key[127:0] ^ eng_key[255:128] ^ {125'd0, eng_mode}) :
                     (eng_data ^ eng_iv ^ eng_key[127:0] ^ eng_key[255:128] ^ {125'd0, eng_mode});
            end else if (s_cnt > 0) begin
                s_cnt <= s_cnt - 1;
                if (s_cnt == 1) eng_done <= 1'b1;
            end
        end
    end
    assign eng_result  = s_res;
    assign eng_next_iv = {s_res[63:0], s_res[127:64]};

    // ---------------- reference model ----------------
    logic [31:0] mk [8];
    logic [31:0] miv [4];
    logic [31:0] mid [4];
    logic [31:0] mod [4];
    logic        m_dec, m_sm, m_ars, m_prep, m_aiu;
    logic [2:0]  m_mode;
    logic [1:0]  m_kc;
    logic        m_busy, m_start, m_err, m_kv, m_prep_at;
    int          w;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) mk[i] <= '0;
            for (int i = 0; i < 4; i++) begin miv[i] <= '0; mid[i] <= '0; mod[i] <= '0; end
            {m_dec, m_sm, m_ars, m_prep, m_aiu} <= '0;
            m_mode <= '0; m_kc <= '0;
            {m_busy, m_start, m_err, m_kv, m_prep_at} <= '0;
        end else begin
            m_start <= 1'b0;
            if (bus_wr && !m_busy) begin
                w = int'(bus_addr) / 4;
                if (w == 0) begin
                    m_dec  <= bus_wdata[0];   m_mode <= bus_wdata[3:1];
                    m_kc   <= bus_wdata[5:4]; m_sm   <= bus_wdata[6];
                    m_ars  <= bus_wdata[7];   m_prep <= bus_wdata[8];
                    m_aiu  <= bus_wdata[9];
                    if (bus_wdata[12]) m_err <= 1'b0;
                end else if (w >= 1 && w <= 8) begin
                    mk[8 - w] <= bus_wdata;
                    m_kv <= 1'b0;
                end else if (w >= 9 && w <= 12) begin
                    miv[12 - w] <= bus_wdata;
                end else if (w >= 13 && w <= 16) begin
                    mid[16 - w] <= bus_wdata;
                    if (w == 16 && m_sm && m_ars) begin
                        if (m_mode <= 3'd4 && m_kc != 2'd3) begin
                            m_busy <= 1'b1; m_start <= 1'b1; m_prep_at <= m_prep;
                        end else begin
                            m_err <= 1'b1;
                        end
                    end
                end
            end
            if (m_busy && eng_done) begin
                for (int i = 0; i < 4; i++) begin
                    mod[i] <= eng_result[i*32 +: 32];
                    if (m_aiu) miv[i] <= eng_next_iv[i*32 +: 32];
                end
                if (m_prep_at) m_kv <= 1'b1;
                m_busy <= 1'b0;
            end
        end
    end

    function automatic logic [255:0] m_keyflat();
        logic [255:0] f;
        for (int i = 0; i < 8; i++) f[i*32 +: 32] = mk[i];
        return f;
    endfunction

    function automatic logic [127:0] m_blk(input int which);
        logic [127:0] f;
        for (int i = 0; i < 4; i++) f[i*32 +: 32] = (which == 0) ? miv[i] : mid[i];
        return f;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        int ww;
        ww = int'(a) / 4;
        if (ww == 0)
            return {19'd0, m_err, m_kv, m_busy, m_aiu, m_prep, m_ars, m_sm, m_kc, m_mode, m_dec};
        if (ww >= 9 && ww <= 12)  return miv[12 - ww];
        if (ww >= 13 && ww <= 16) return mid[16 - ww];
        if (ww >= 17 && ww <= 20) return mod[20 - ww];
        return 32'd0;
    endfunction

    // ---------------- checking ----------------
    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                       input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(eng_start == m_start, "R5 start pulse", 256'(eng_start), 256'(m_start));
            chk(eng_key == m_keyflat(), "R3 key bus", eng_key, m_keyflat());
            chk(eng_iv == m_blk(0), "R8 iv bus", 256'(eng_iv), 256'(m_blk(0)));
            chk(eng_data == m_blk(1), "R7 data bus", 256'(eng_data), 256'(m_blk(1)));
            chk({eng_key_code, eng_mode, eng_decrypt} == {m_kc, m_mode, m_dec},
                "R4 mode/dir/keycode", 256'({eng_key_code, eng_mode, eng_decrypt}),
                256'({m_kc, m_mode, m_dec}));
            chk(eng_prep_key == (m_prep | (m_dec & ~m_kv)), "R9 prep request",
                256'(eng_prep_key), 256'(m_prep | (m_dec & ~m_kv)));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; e = m_read(a);
        @(negedge clk);
        bus_rd = 1'b0;
        chk(bus_rdata == e, tag, 256'(bus_rdata), 256'(e));
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic load_block(input logic [31:0] base);
        for (int i = 0; i < 4; i++) wr(8'h34 + 8'(4 * i), base + 32'(i));
    endtask

    task automatic read_outputs(input string tag);
        for (int i = 0; i < 4; i++) rd_chk(8'h44 + 8'(4 * i), tag);
    endtask

    task automatic read_ivs(input string tag);
        for (int i = 0; i < 4; i++) rd_chk(8'h24 + 8'(4 * i), tag);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (5) @(negedge clk);
        // R1 reset state at the ports
        chk(bus_rdata == 32'd0, "R1 rdata in reset", 256'(bus_rdata), 256'd0);
        chk(eng_start == 1'b0, "R1 no start in reset", 256'(eng_start), 256'd0);
        chk(eng_key == '0, "R1 key cleared", eng_key, 256'd0);
        rst = 1'b0;
        rd_chk(8'h00, "R1 control after reset");
        rd_chk(8'h50, "R1 output word after reset");

        // R3 256-bit key, ECB encrypt
        for (int i = 0; i < 8; i++) wr(8'h04 + 8'(4 * i), 32'hA0000000 + 32'(i));
        rd_chk(8'h04, "R2 key word reads zero");
        rd_chk(8'h60, "R2 unmapped reads zero");
        wr(8'h00, 32'h0000_00E0);
        chk(eng_key[255:224] == 32'hA0000000, "R3 first word at top of 256-bit key",
            256'(eng_key[255:224]), 256'(32'hA0000000));
        chk(eng_key_code == 2'd2, "R3 code 2 for 256-bit", 256'(eng_key_code), 256'd2);
        load_block(32'h1000_0000);
        rd_chk(8'h00, "R6 busy visible");
        wait_idle();
        read_outputs("R6 output words");
        rd_chk(8'h00, "R6 busy cleared");

        // R3 128-bit key, CBC, IV not auto-updated
        for (int i = 0; i < 4; i++) wr(8'h14 + 8'(4 * i), 32'hB0000000 + 32'(i));
        chk(eng_key[127:96] == 32'hB0000000, "R3 first word at top of 128-bit key",
            256'(eng_key[127:96]), 256'(32'hB0000000));
        for (int i = 0; i < 4; i++) wr(8'h24 + 8'(4 * i), 32'hC0000000 + 32'(i));
        wr(8'h00, 32'h0000_00C2);
        chk(eng_mode == 3'd1, "R4 CBC code", 256'(eng_mode), 256'd1);
        load_block(32'h2000_0000);
        wait_idle();
        read_ivs("R8 IV unchanged without auto-update");
        read_outputs("R6 CBC output");

        // R8 auto-update on
        wr(8'h00, 32'h0000_02C2);
        wr(8'h40, 32'h3333_0000);
        wait_idle();
        read_ivs("R8 IV auto-updated");

        // R7 writes dropped while busy
        wr(8'h00, 32'h0000_00C4);
        wr(8'h40, 32'h4444_0000);
        wr(8'h20, 32'hDEAD_0001);
        wr(8'h30, 32'hDEAD_0002);
        wr(8'h00, 32'h0000_0000);
        wr(8'h40, 32'hDEAD_0003);
        rd_chk(8'h00, "R7 control kept while busy");
        wait_idle();
        rd_chk(8'h30, "R7 IV0 write dropped");
        rd_chk(8'h40, "R7 ID0 write dropped");
        read_outputs("R7 single result");

        // R5 no launch without start mode
        wr(8'h00, 32'h0000_0086);
        chk(eng_mode == 3'd3, "R4 CFB code", 256'(eng_mode), 256'd3);
        wr(8'h40, 32'h5555_0000);
        repeat (3) @(negedge clk);
        rd_chk(8'h00, "R5 no busy without start mode");
        rd_chk(8'h40, "R5 data stored");

        // R9 decrypt 192-bit, key not valid -> prep requested
        for (int i = 0; i < 6; i++) wr(8'h0C + 8'(4 * i), 32'hD0000000 + 32'(i));
        wr(8'h00, 32'h0000_00D9);
        chk(eng_prep_key == 1'b1, "R9 prep forced for decrypt", 256'(eng_prep_key), 256'd1);
        chk(eng_decrypt == 1'b1, "R4 decrypt bit", 256'(eng_decrypt), 256'd1);
        wr(8'h00, 32'h0000_01D9);
        wr(8'h40, 32'h6666_0000);
        wait_idle();
        rd_chk(8'h00, "R9 key valid set");
        wr(8'h00, 32'h0000_00D9);
        chk(eng_prep_key == 1'b0, "R9 no prep once valid", 256'(eng_prep_key), 256'd0);
        wr(8'h20, 32'h1234_5678);
        chk(eng_prep_key == 1'b1, "R9 key write clears valid", 256'(eng_prep_key), 256'd1);
        rd_chk(8'h00, "R9 key valid cleared");

        // R10 reserved mode and key code
        wr(8'h00, 32'h0000_00CA);
        wr(8'h40, 32'h7777_0000);
        repeat (2) @(negedge clk);
        rd_chk(8'h00, "R10 error on mode 5");
        wr(8'h00, 32'h0000_10C4);
        rd_chk(8'h00, "R10 error cleared");
        wr(8'h00, 32'h0000_00F0);
        wr(8'h40, 32'h8888_0000);
        repeat (2) @(negedge clk);
        rd_chk(8'h00, "R10 error on key code 3");
        wr(8'h00, 32'h0000_00C0);
        rd_chk(8'h00, "R10 error sticky");

        // R4 OFB and CTR launches
        wr(8'h00, 32'h0000_10C4);
        load_block(32'h9000_0000);
        wait_idle();
        read_outputs("R4 OFB output");
        wr(8'h00, 32'h0000_00C8);
        wr(8'h40, 32'hAAAA_0000);
        wait_idle();
        read_outputs("R4 CTR output");

        summary();
    end

endmodule